// File: doc/BRIEF.md
# Processor control register unit

This block is the control register file of a small 32-bit processor core. The core addresses it through a 4-bit control-register index, with one combinational read port and one clocked write port. It keeps the processor status word, its backup and double-backup copies, the condition bit, the backup and double-backup program counters, and two spare 32-bit words.

The interrupt and user stack pointers are banked with general register 15. The unit owns the live stack pointer, meaning the value that register 15 holds, and drives it to the general register file on `sp_live`. The register file sends its own writes of register 15 back on the `gr_sp_*` pins. Bit 7 of the status word is the stack-mode bit. It decides which of the two pointers is live and which is kept as a saved copy. A status-word write that changes this bit swaps them.

All writes take effect on the rising clock edge. Reads show the current register state in the same cycle. The reset input is asynchronous and active low. Inside the unit it is released in step with the clock, and it clears every register.

Top module: `ctrlreg_unit`

## Requirements
- R1: After reset every index reads 0 and `sp_live` is 0.
- R2: A read of index 0 (status word) returns the backup status ANDed with 0xC1 in bits 15:8, status bits 7:6 in bits 7:6, and the condition bit in bit 0. All other bits read 0.
- R3: A write to index 0 loads the backup status from data bits 15:8, the status from bits 7:0 (bit 7 is the stack mode), and the condition bit from bit 0.
- R4: A write to index 0 that takes the stack mode from 1 to 0 saves the old live pointer as the user SP and loads the live pointer from the saved interrupt SP.
- R5: A write to index 0 that takes the stack mode from 0 to 1 saves the old live pointer as the interrupt SP and loads the live pointer from the saved user SP.
- R6: Index 2 (interrupt SP) reads and writes the live pointer when the mode is 0 and the saved copy when it is 1. Index 3 (user SP) makes the opposite choice.
- R7: Indices 6 and 7 (backup PC, double-backup PC) store all 32 bits and read back with bit 0 cleared.
- R8: Index 8 (double-backup status) is written from data bits 7:0 and reads back ANDed with 0xC1. Index 1 (condition bit) writes and reads bit 0 only and leaves the stack mode unchanged.
- R9: Indices 4 and 5 are plain 32-bit read/write storage.
- R10: Every other index (9 to 15) reads 0. A write to one of them changes no register and does not change `sp_live`.
- R11: A write of general register 15 loads the live pointer at the next edge. If a control-register write to the live pointer falls in the same cycle, that write wins. This covers index 2 or 3 routed to the live pointer, and a status write that swaps the pointers.
- R12: `sp_live` always shows the live pointer, and a write is visible on it in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_rd_idx | input | 4 | Control-register read index |
| cr_rd_data | output | 32 | Read data, combinational |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wr_idx | input | 4 | Control-register write index |
| cr_wr_data | input | 32 | Control-register write data |
| gr_sp_wr_en | input | 1 | General register 15 write strobe |
| gr_sp_wr_data | input | 32 | General register 15 write data |
| sp_live | output | 32 | Live stack pointer sent to the register file |

## Verification
A general-register write of register 15 can fall in the same cycle as a control-register write that also targets the live pointer. That control-register write is either an SP index routed to the live pointer or a status write that flips the stack mode and swaps the pointers. Directed steps pair a register-15 write with an index-3 write in user mode, and with a mode-flipping status write. The random phase then drives both strobes independently on most cycles. Each result is judged against a bench model in which the control-register write takes priority and the swap uses the pointer value from before the edge, by comparing `sp_live` and a read-back of both SP indices.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  // Control-register index assignment
  localparam int IDX_PSW   = 0;
  localparam int IDX_COND  = 1;
  localparam int IDX_SPI   = 2;
  localparam int IDX_SPU   = 3;
  localparam int IDX_WORD0 = 4;   // first of the plain/backup-PC words (4..7)
  localparam int IDX_BBPSW = 8;

  localparam int NUM_WORDS    = 4;  // indices 4,5 plain, 6,7 backup PCs
  localparam int FIRST_PC_SLT = 2;  // slots from here read with bit 0 cleared

  // Observable status bits kept: {bit7, bit6, bit0} of an 8-bit status
  localparam int KEEP_W = 3;
endpackage

// File: rtl/ctrlreg_rst_sync.sv
module ctrlreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/ctrlreg_status.sv
module ctrlreg_status
  import ctrlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_psw,
  input  logic              wr_cond,
  input  logic              wr_bbpsw,
  input  logic [KEEP_W-1:0] bpsw_wd,   // {d15, d14, d8}
  input  logic [1:0]        psw_wd,    // {d7, d6}
  input  logic              cond_wd,   // d0
  input  logic [KEEP_W-1:0] bbpsw_wd,  // {d7, d6, d0}
  output logic              mode,
  output logic              mode_flip,
  output logic              cond,
  output logic [1:0]        psw_hi,
  output logic [KEEP_W-1:0] bpsw,
  output logic [KEEP_W-1:0] bbpsw
);
  logic [1:0]        psw_q,   psw_d;
  logic              cond_q,  cond_d;
  logic [KEEP_W-1:0] bpsw_q,  bpsw_d;
  logic [KEEP_W-1:0] bbpsw_q, bbpsw_d;
  logic              psw_en, cond_en, bbpsw_en;

  // next-state
  always_comb begin
    psw_en   = wr_psw;
    cond_en  = wr_psw | wr_cond;
    bbpsw_en = wr_bbpsw;
    psw_d    = psw_wd;
    bpsw_d   = bpsw_wd;
    cond_d   = cond_wd;
    bbpsw_d  = bbpsw_wd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q   <= '0;
      bpsw_q  <= '0;
      cond_q  <= 1'b0;
      bbpsw_q <= '0;
    end else begin
      if (psw_en) begin
        psw_q  <= psw_d;
        bpsw_q <= bpsw_d;
      end
      if (cond_en)  cond_q  <= cond_d;
      if (bbpsw_en) bbpsw_q <= bbpsw_d;
    end
  end

  assign mode      = psw_q[1];
  assign mode_flip = wr_psw && (psw_wd[1] != psw_q[1]);
  assign cond      = cond_q;
  assign psw_hi    = psw_q;
  assign bpsw      = bpsw_q;
  assign bbpsw     = bbpsw_q;

  // R3: a status write lands mode and condition from the written fields
  p_status_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_psw |=> (mode == $past(psw_wd[1])) && (cond == $past(cond_wd)));

  // R8: condition-bit write touches only the condition bit
  p_cond_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_psw) |=> (cond == $past(cond_wd)) && (mode == $past(mode)));
endmodule

// File: rtl/ctrlreg_spbank.sv
module ctrlreg_spbank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              flip,
  input  logic              wr_spi,
  input  logic              wr_spu,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              gr_we,
  input  logic [DATA_W-1:0] gr_data,
  output logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] spi_view,
  output logic [DATA_W-1:0] spu_view
);
  logic [DATA_W-1:0] live_q, live_d;
  logic [DATA_W-1:0] spi_q,  spi_d;
  logic [DATA_W-1:0] spu_q,  spu_d;
  logic              live_en, spi_en, spu_en;

  // next-state; later assignments take priority over earlier ones
  always_comb begin
    live_en = 1'b0;
    spi_en  = 1'b0;
    spu_en  = 1'b0;
    live_d  = live_q;
    spi_d   = spi_q;
    spu_d   = spu_q;
    if (gr_we) begin
      live_en = 1'b1;
      live_d  = gr_data;
    end
    if (flip) begin
      live_en = 1'b1;
      if (mode) begin          // 1 -> 0
        spu_en = 1'b1;
        spu_d  = live_q;
        live_d = spi_q;
      end else begin           // 0 -> 1
        spi_en = 1'b1;
        spi_d  = live_q;
        live_d = spu_q;
      end
    end
    if (wr_spi) begin
      if (!mode) begin
        live_en = 1'b1;
        live_d  = wr_data;
      end else begin
        spi_en = 1'b1;
        spi_d  = wr_data;
      end
    end
    if (wr_spu) begin
      if (mode) begin
        live_en = 1'b1;
        live_d  = wr_data;
      end else begin
        spu_en = 1'b1;
        spu_d  = wr_data;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      spi_q  <= '0;
      spu_q  <= '0;
    end else begin
      if (live_en) live_q <= live_d;
      if (spi_en)  spi_q  <= spi_d;
      if (spu_en)  spu_q  <= spu_d;
    end
  end

  assign live     = live_q;
  assign spi_view = mode ? spi_q  : live_q;
  assign spu_view = mode ? live_q : spu_q;

  // R4: leaving mode 1 parks the live pointer as user SP, restores interrupt SP
  p_swap_to0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && mode) |=> (live == $past(spi_q)) && (spu_q == $past(live_q)));

  // R5: entering mode 1 parks the live pointer as interrupt SP, restores user SP
  p_swap_to1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !mode) |=> (live == $past(spu_q)) && (spi_q == $past(live_q)));

  // R11: a general-register write lands when no control write targets the live pointer
  p_gr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we && !flip && !(wr_spi && !mode) && !(wr_spu && mode))
      |=> live == $past(gr_data));

  // R11: control write to the live pointer beats the general-register write
  p_cr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we && ((wr_spi && !mode) || (wr_spu && mode))) |=> live == $past(wr_data));

  // R10: with no write input active the bank holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gr_we && !flip && !wr_spi && !wr_spu)
      |=> $stable(live_q) && $stable(spi_q) && $stable(spu_q));
endmodule

// File: rtl/ctrlreg_words.sv
module ctrlreg_words
  import ctrlreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORD  = NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWORD-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word [NWORD]
);
  localparam logic [DATA_W-1:0] EVEN_MASK = ~{{(DATA_W-1){1'b0}}, 1'b1};

  for (genvar s = 0; s < NWORD; s++) begin : g_slot
    logic [DATA_W-1:0] word_q, word_d;
    logic              word_en;

    always_comb begin
      word_en = wr_sel[s];
      word_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    if (s >= FIRST_PC_SLT) begin : g_pc
      assign rd_word[s] = word_q & EVEN_MASK;
    end else begin : g_plain
      assign rd_word[s] = word_q;
    end

    // R9: a selected slot captures the whole written word
    p_word_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[s] |=> word_q == $past(wr_data));
  end
endmodule

// File: rtl/ctrlreg_rdmux.sv
module ctrlreg_rdmux
  import ctrlreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] psw_rd,
  input  logic              cond,
  input  logic [DATA_W-1:0] spi_view,
  input  logic [DATA_W-1:0] spu_view,
  input  logic [DATA_W-1:0] words [NUM_WORDS],
  input  logic [KEEP_W-1:0] bbpsw,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (idx == IDX_W'(IDX_PSW)) begin
      rd_data = psw_rd;
    end else if (idx == IDX_W'(IDX_COND)) begin
      rd_data[0] = cond;
    end else if (idx == IDX_W'(IDX_SPI)) begin
      rd_data = spi_view;
    end else if (idx == IDX_W'(IDX_SPU)) begin
      rd_data = spu_view;
    end else if (idx == IDX_W'(IDX_BBPSW)) begin
      rd_data[7] = bbpsw[2];
      rd_data[6] = bbpsw[1];
      rd_data[0] = bbpsw[0];
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (idx == IDX_W'(IDX_WORD0 + w)) rd_data = words[w];
      end
    end
  end
endmodule

// File: rtl/ctrlreg_unit.sv
module ctrlreg_unit
  import ctrlreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cr_rd_idx,
  output logic [DATA_W-1:0] cr_rd_data,
  input  logic              cr_wr_en,
  input  logic [IDX_W-1:0]  cr_wr_idx,
  input  logic [DATA_W-1:0] cr_wr_data,
  input  logic              gr_sp_wr_en,
  input  logic [DATA_W-1:0] gr_sp_wr_data,
  output logic [DATA_W-1:0] sp_live
);
  localparam int HI_PAD = DATA_W - 16;

  logic              rst_ni;
  logic              wr_psw, wr_cond, wr_spi, wr_spu, wr_bbpsw;
  logic [NUM_WORDS-1:0] wr_word;
  logic              mode, flip, cond;
  logic [1:0]        psw_hi;
  logic [KEEP_W-1:0] bpsw, bbpsw;
  logic [DATA_W-1:0] spi_view, spu_view;
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] psw_rd;

  ctrlreg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_ni)
  );

  // write decode
  always_comb begin
    wr_psw   = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_PSW));
    wr_cond  = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_COND));
    wr_spi   = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_SPI));
    wr_spu   = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_SPU));
    wr_bbpsw = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_BBPSW));
    for (int w = 0; w < NUM_WORDS; w++)
      wr_word[w] = cr_wr_en && (cr_wr_idx == IDX_W'(IDX_WORD0 + w));
  end

  ctrlreg_status u_status (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_psw    (wr_psw),
    .wr_cond   (wr_cond),
    .wr_bbpsw  (wr_bbpsw),
    .bpsw_wd   ({cr_wr_data[15], cr_wr_data[14], cr_wr_data[8]}),
    .psw_wd    (cr_wr_data[7:6]),
    .cond_wd   (cr_wr_data[0]),
    .bbpsw_wd  ({cr_wr_data[7], cr_wr_data[6], cr_wr_data[0]}),
    .mode      (mode),
    .mode_flip (flip),
    .cond      (cond),
    .psw_hi    (psw_hi),
    .bpsw      (bpsw),
    .bbpsw     (bbpsw)
  );

  ctrlreg_spbank #(.DATA_W(DATA_W)) u_spbank (
    .clk      (clk),
    .rst_n    (rst_ni),
    .mode     (mode),
    .flip     (flip),
    .wr_spi   (wr_spi),
    .wr_spu   (wr_spu),
    .wr_data  (cr_wr_data),
    .gr_we    (gr_sp_wr_en),
    .gr_data  (gr_sp_wr_data),
    .live     (sp_live),
    .spi_view (spi_view),
    .spu_view (spu_view)
  );

  ctrlreg_words #(.DATA_W(DATA_W), .NWORD(NUM_WORDS)) u_words (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_sel  (wr_word),
    .wr_data (cr_wr_data),
    .rd_word (words)
  );

  // status word read image: backup bits 15,14,8 / status 7,6 / condition 0
  assign psw_rd = {{HI_PAD{1'b0}}, bpsw[2], bpsw[1], 5'b0, bpsw[0],
                   psw_hi, 5'b0, cond};

  ctrlreg_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdmux (
    .idx      (cr_rd_idx),
    .psw_rd   (psw_rd),
    .cond     (cond),
    .spi_view (spi_view),
    .spu_view (spu_view),
    .words    (words),
    .bbpsw    (bbpsw),
    .rd_data  (cr_rd_data)
  );

  // R6: in mode 0 the interrupt SP index shows the pointer the register file sees
  p_spi_live_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_rd_idx == IDX_W'(IDX_SPI) && !mode) |-> cr_rd_data == sp_live);

  // R6: in mode 1 the user SP index shows the pointer the register file sees
  p_spu_live_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_rd_idx == IDX_W'(IDX_SPU) && mode) |-> cr_rd_data == sp_live);

  // R10: unassigned indices read zero
  p_unassigned_zero_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_rd_idx > IDX_W'(IDX_BBPSW)) |-> cr_rd_data == '0);

  // R7: a backup PC written and read next cycle returns the value with bit 0 cleared
  p_pc_even_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_wr_en && cr_wr_idx == IDX_W'(IDX_WORD0 + 2) && cr_rd_idx == IDX_W'(IDX_WORD0 + 2))
      |=> (cr_rd_idx != IDX_W'(IDX_WORD0 + 2)) ||
          (cr_rd_data == ($past(cr_wr_data) & ~DATA_W'(1))));
endmodule

// File: tb/ctrlreg_unit_tb_top.sv
`timescale 1ns/1ps
module ctrlreg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cr_rd_idx;
  logic [31:0] cr_rd_data;
  logic        cr_wr_en;
  logic [3:0]  cr_wr_idx;
  logic [31:0] cr_wr_data;
  logic        gr_sp_wr_en;
  logic [31:0] gr_sp_wr_data;
  logic [31:0] sp_live;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the architectural state
  logic [7:0]  m_bpsw, m_psw, m_bbpsw;
  logic        m_cond;
  logic [31:0] m_live, m_spi, m_spu, m_r4, m_r5, m_bpc, m_bbpc;

  always #4 clk = ~clk;   // 125 MHz

  ctrlreg_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cr_rd_idx     (cr_rd_idx),
    .cr_rd_data    (cr_rd_data),
    .cr_wr_en      (cr_wr_en),
    .cr_wr_idx     (cr_wr_idx),
    .cr_wr_data    (cr_wr_data),
    .gr_sp_wr_en   (gr_sp_wr_en),
    .gr_sp_wr_data (gr_sp_wr_data),
    .sp_live       (sp_live)
  );

  task automatic model_reset();
    m_bpsw = 0; m_psw = 0; m_bbpsw = 0; m_cond = 0;
    m_live = 0; m_spi = 0; m_spu = 0;
    m_r4 = 0; m_r5 = 0; m_bpc = 0; m_bbpc = 0;
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] idx);
    case (idx)
      4'd0: return {16'h0, m_bpsw & 8'hC1, (m_psw & 8'hC0) | {7'b0, m_cond}};
      4'd1: return {31'b0, m_cond};
      4'd2: return m_psw[7] ? m_spi : m_live;
      4'd3: return m_psw[7] ? m_live : m_spu;
      4'd4: return m_r4;
      4'd5: return m_r5;
      4'd6: return m_bpc & 32'hFFFF_FFFE;
      4'd7: return m_bbpc & 32'hFFFF_FFFE;
      4'd8: return {24'h0, m_bbpsw & 8'hC1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] idx);
    case (idx)
      4'd0: return "R2";
      4'd1, 4'd8: return "R8";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5: return "R9";
      4'd6, 4'd7: return "R7";
      default: return "R10";
    endcase
  endfunction

  // next state from the requirements; control write beats register-15 write
  task automatic model_step(input bit we, input logic [3:0] idx, input logic [31:0] d,
                            input bit gwe, input logic [31:0] gd);
    logic [31:0] n_live, n_spi, n_spu;
    n_live = m_live; n_spi = m_spi; n_spu = m_spu;
    if (gwe) n_live = gd;
    if (we) begin
      case (idx)
        4'd0: begin
          if (m_psw[7] && !d[7]) begin n_spu = m_live; n_live = m_spi; end
          if (!m_psw[7] && d[7]) begin n_spi = m_live; n_live = m_spu; end
          m_bpsw = d[15:8]; m_psw = d[7:0]; m_cond = d[0];
        end
        4'd1: m_cond = d[0];
        4'd2: if (!m_psw[7]) n_live = d; else n_spi = d;
        4'd3: if (m_psw[7]) n_live = d; else n_spu = d;
        4'd4: m_r4 = d;
        4'd5: m_r5 = d;
        4'd6: m_bpc = d;
        4'd7: m_bbpc = d;
        4'd8: m_bbpsw = d[7:0];
        default: ;
      endcase
    end
    m_live = n_live; m_spi = n_spi; m_spu = n_spu;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [3:0] idx, input logic [31:0] d,
                     input bit gwe, input logic [31:0] gd);
    @(negedge clk);
    cr_wr_en = we; cr_wr_idx = idx; cr_wr_data = d;
    gr_sp_wr_en = gwe; gr_sp_wr_data = gd;
    @(posedge clk);
    model_step(we, idx, d, gwe, gd);
    #1;
    cr_wr_en = 1'b0; gr_sp_wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] idx);
    cr_rd_idx = idx;
    #0.5;
    check(tag, cr_rd_data, exp_read(idx));
  endtask

  task automatic sp_chk(input string tag);
    check(tag, sp_live, m_live);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 16; i++) rd(tag, 4'(i));
    sp_chk(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    cr_rd_idx = 0; cr_wr_en = 0; cr_wr_idx = 0; cr_wr_data = 0;
    gr_sp_wr_en = 0; gr_sp_wr_data = 0;
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd_all("R1 reset");

    // R11 register-15 write, R12 visibility
    cyc(0, 0, 0, 1, 32'h0000_1000);   sp_chk("R11 gr write"); sp_chk("R12");
    // R6 in mode 0: index 2 is live, index 3 is saved
    cyc(1, 2, 32'h0000_2222, 0, 0);   sp_chk("R6 spi live"); rd("R6", 2); rd("R6", 3);
    cyc(1, 3, 32'h0000_3330, 0, 0);   sp_chk("R6 spu saved"); rd("R6", 3);
    // R5 mode 0 -> 1
    cyc(1, 0, 32'h0000_0080, 0, 0);   sp_chk("R5 swap"); rd("R5", 2); rd("R5", 3); rd("R2", 0);
    // R11 control write wins over register-15 write (index 3, mode 1)
    cyc(1, 3, 32'h0000_5554, 1, 32'h0000_AAAA); sp_chk("R11 cr wins");
    // R4 mode 1 -> 0, with fields R3
    cyc(1, 0, 32'h0000_FF41, 0, 0);   sp_chk("R4 swap"); rd("R4", 3); rd("R4", 2); rd("R3", 0);
    // R3 write with no mode change leaves pointers
    cyc(1, 0, 32'hFFFF_0001, 0, 0);   sp_chk("R3 no swap"); rd("R3", 0); rd("R3", 1);
    // R11 swap plus register-15 write in the same cycle
    cyc(1, 0, 32'h0000_00C0, 1, 32'h0000_BEEF); sp_chk("R11 swap wins"); rd("R11", 2); rd("R11", 3);
    // R7 backup PCs
    cyc(1, 6, 32'hFFFF_FFFF, 0, 0);   rd("R7", 6);
    cyc(1, 7, 32'h1234_5679, 0, 0);   rd("R7", 7);
    // R8 double-backup status and condition bit
    cyc(1, 8, 32'hABCD_FFFF, 0, 0);   rd("R8", 8);
    cyc(1, 1, 32'hFFFF_FFFE, 0, 0);   rd("R8", 1); rd("R8 mode kept", 0); sp_chk("R8");
    cyc(1, 1, 32'h0000_0003, 0, 0);   rd("R8", 1);
    // R9 plain words
    cyc(1, 4, 32'hDEAD_BEEF, 0, 0);   rd("R9", 4);
    cyc(1, 5, 32'h0BAD_F00D, 0, 0);   rd("R9", 5);
    // R10 unassigned writes ignored
    cyc(1, 9, 32'hFFFF_FFFF, 0, 0);   rd_all("R10");
    cyc(1, 15, 32'hFFFF_FFFF, 0, 0);  rd_all("R10");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] wi, ri;
      wi = 4'($urandom_range(0, 15));
      ri = 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 3) != 0, wi, $urandom(),
          $urandom_range(0, 2) == 0, $urandom());
      sp_chk("R12 random");
      rd(req_of(ri), ri);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule